// File: doc/BRIEF.md
# Ethernet Receive Status and Error Tally Unit

This unit sits beside an Ethernet receive datapath. It turns that datapath's per-frame event strobes into an 8-bit status word for each frame. It also keeps three error tallies, so the host never has to watch every frame's status as it arrives.

A frame opens with `frameStart`. It closes with either `frameEnd` or a FIFO overflow. At the close, the unit encodes the following into the status word:
- the CRC result;
- the dribble-bit alignment;
- a missed-frame condition;
- the address-match type.

Two further status bits follow the live monitor-mode control and the carrier/jabber sense. When the closing frame must be written to buffer memory, a one-cycle `statusWrite` pulse asks the DMA to write the word. Good frames are always written. Errored frames are written only when `saveErrored` is set.

The three 8-bit tallies count CRC-only errors, alignment errors and missed frames. Each tally stops at 255 instead of wrapping. A tally is cleared by pulsing its bit of `rdTally` in the same cycle in which the host samples it.

Top module: `rxStatTally`

## Requirements
- R1: After reset, `statusWord`, all three tallies, `tallyMsb` and `statusWrite` are zero.
- R2: A `frameStart` clears status bits 5..0 on the next clock edge and opens a frame.
- R3: At frame end, bit 1 (CRC) = !crcOk, and bit 2 (alignment) = !crcOk && dribbleBits >= 6. A good CRC gives no error whatever the dribble count. Bit 2 is never set while bit 1 is clear.
- R4: At frame end, bit 4 (missed) = noBuffer | monitorMode. Bit 0 (intact) is set exactly when bits 1..4 are all clear.
- R5: At frame end, bit 5 = multiMatch: 0 for a unicast match, 1 for a multicast or broadcast match.
- R6: A `fifoOvf` inside a frame aborts that frame. It sets bit 3, clears bit 0, and leaves bits 1, 2, 4 and 5 at zero. No tally counts the aborted frame.
- R7: `statusWrite` pulses for one cycle after a frame closes. For a frame end, it pulses when the frame is not missed and is either good or `saveErrored` is 1. For an overflow abort, it pulses when `saveErrored` is 1.
- R8: Bit 6 follows `monitorMode`, and bit 7 follows `carrierSense | jabber`. Both lag their inputs by one cycle and are unaffected by frame events.
- R9: At frame end, three tallies can advance. Tally 0 (`crcTally`) increments for a CRC error without an alignment error. Tally 1 (`alignTally`) increments for an alignment error. Tally 2 (`missTally`) increments for a missed frame.
- R10: A tally at 255 stays at 255 on further increments.
- R11: A tally whose `rdTally` bit is 1 shows its current value during that cycle and is zero after the edge. If an increment coincides with the read, the tally is one after the edge.
- R12: `tallyMsb[i]` is 1 exactly when bit 7 of tally i is set.
- R13: A `frameEnd` or `fifoOvf` outside an open frame has no effect: the status, the tallies and `statusWrite` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | First-byte strobe of an incoming frame |
| frameEnd | input | 1 | Last-byte strobe of the frame |
| crcOk | input | 1 | CRC matched at the last whole byte, valid with frameEnd |
| dribbleBits | input | 3 | Count of bits past the last byte boundary, valid with frameEnd |
| fifoOvf | input | 1 | Receive FIFO overflow strobe |
| noBuffer | input | 1 | No free receive buffer, valid with frameEnd |
| multiMatch | input | 1 | 1 = multicast or broadcast match, 0 = unicast match |
| carrierSense | input | 1 | Carrier or collision sensed |
| jabber | input | 1 | Jabber condition present |
| monitorMode | input | 1 | Receiver in monitor mode (frames not buffered) |
| saveErrored | input | 1 | Write status for errored frames too |
| rdTally | input | 3 | Per-tally read-and-clear strobes (0 CRC, 1 alignment, 2 missed) |
| statusWord | output | 8 | Live receive status word |
| statusWrite | output | 1 | One-cycle request to write statusWord to memory |
| crcTally | output | 8 | CRC-only error tally |
| alignTally | output | 8 | Alignment error tally |
| missTally | output | 8 | Missed frame tally |
| tallyMsb | output | 3 | Per-tally bit 7 flags |

## Verification
Every result is registered once. The status bits, `statusWrite`, and the tally increments and clears are all due on the first clock edge after the cycle in which the event strobe is presented. The bench drives inputs just after a rising edge and samples outputs one time unit after the following rising edge, so each check lands in exactly the cycle the result is due. A read-clear's pre-clear value is checked before its edge and its cleared value after it. The expected words come from bench functions that apply the encoding rules to the randomly drawn inputs of each frame.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int STAT_W        = 8;
  localparam int DRIB_W        = 3;
  localparam int DRIBBLE_LIMIT = 6;
  localparam int NUM_TALLY     = 3;
  localparam int CNT_W         = 8;

  localparam int BIT_INTACT = 0;
  localparam int BIT_CRC    = 1;
  localparam int BIT_ALIGN  = 2;
  localparam int BIT_OVR    = 3;
  localparam int BIT_MISS   = 4;
  localparam int BIT_MULTI  = 5;
  localparam int BIT_MON    = 6;
  localparam int BIT_DEFER  = 7;

  localparam int T_CRC   = 0;
  localparam int T_ALIGN = 1;
  localparam int T_MISS  = 2;

  typedef struct packed {
    logic                 clearStat;
    logic                 loadEnd;
    logic                 loadOvf;
    logic                 writeReq;
    logic                 crcErr;
    logic                 alignErr;
    logic                 missed;
    logic [NUM_TALLY-1:0] incTally;
  } ctrlStrobes_t;
endpackage

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl
  import rxstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              crcOk,
  input  logic [DRIB_W-1:0] dribbleBits,
  input  logic              fifoOvf,
  input  logic              noBuffer,
  input  logic              monitorMode,
  input  logic              saveErrored,
  output ctrlStrobes_t      strb
);
  logic inFrame;
  logic crcE, alignE, missE, goodE;

  assign crcE   = !crcOk;
  assign alignE = crcE && (int'(dribbleBits) >= DRIBBLE_LIMIT);
  assign missE  = noBuffer || monitorMode;
  assign goodE  = !crcE && !missE;

  always_comb begin
    strb = '0;
    if (frameStart) begin
      strb.clearStat = 1'b1;
    end else if (inFrame && fifoOvf) begin
      strb.loadOvf  = 1'b1;
      strb.writeReq = saveErrored;
    end else if (inFrame && frameEnd) begin
      strb.loadEnd  = 1'b1;
      strb.crcErr   = crcE;
      strb.alignErr = alignE;
      strb.missed   = missE;
      strb.writeReq = !missE && (goodE || saveErrored);
      strb.incTally[T_CRC]   = crcE && !alignE;
      strb.incTally[T_ALIGN] = alignE;
      strb.incTally[T_MISS]  = missE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               inFrame <= 1'b0;
    else if (frameStart)                     inFrame <= 1'b1;
    else if (inFrame && (fifoOvf || frameEnd)) inFrame <= 1'b0;
  end

  // R6: an overflow closes the frame, so a later frame end finds it closed
  assert_abort_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inFrame && fifoOvf && !frameStart) |=> !inFrame);
  // R13: with no frame open, neither closing strobe produces a load
  assert_idle_ignored_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!inFrame && !frameStart) |-> !(strb.loadEnd || strb.loadOvf || strb.writeReq));
endmodule

// File: rtl/rxstat_dp.sv
module rxstat_dp
  import rxstat_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobes_t                        strb,
  input  logic                                multiMatch,
  input  logic                                monitorMode,
  input  logic                                carrierSense,
  input  logic                                jabber,
  input  logic [NUM_TALLY-1:0]                rdTally,
  output logic [STAT_W-1:0]                   statusWord,
  output logic                                statusWrite,
  output logic [NUM_TALLY-1:0][CNT_W-1:0]     tallies
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord  <= '0;
      statusWrite <= 1'b0;
    end else begin
      statusWrite           <= strb.writeReq;
      statusWord[BIT_MON]   <= monitorMode;
      statusWord[BIT_DEFER] <= carrierSense || jabber;
      if (strb.clearStat) begin
        statusWord[BIT_MULTI:BIT_INTACT] <= '0;
      end else if (strb.loadOvf) begin
        statusWord[BIT_OVR]    <= 1'b1;
        statusWord[BIT_INTACT] <= 1'b0;
      end else if (strb.loadEnd) begin
        statusWord[BIT_INTACT] <= !strb.crcErr && !strb.missed;
        statusWord[BIT_CRC]    <= strb.crcErr;
        statusWord[BIT_ALIGN]  <= strb.alignErr;
        statusWord[BIT_OVR]    <= 1'b0;
        statusWord[BIT_MISS]   <= strb.missed;
        statusWord[BIT_MULTI]  <= multiMatch;
      end
    end
  end

  for (genvar i = 0; i < NUM_TALLY; i++) begin : g_tally
    always_ff @(posedge clk) begin
      if (!rstN)                                 tallies[i] <= '0;
      else if (rdTally[i])                       tallies[i] <= strb.incTally[i] ? CNT_W'(1) : '0;
      else if (strb.incTally[i] && tallies[i] != CNT_MAX) tallies[i] <= tallies[i] + 1'b1;
    end

    assert_tally_saturate_R10: assert property (@(posedge clk) disable iff (!rstN)
      (tallies[i] == CNT_MAX && !rdTally[i]) |=> tallies[i] == CNT_MAX);
    assert_tally_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
      rdTally[i] |=> tallies[i] <= CNT_W'(1));
  end

  assert_align_implies_crc_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_ALIGN] |-> statusWord[BIT_CRC]);
  assert_intact_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BIT_INTACT] |-> statusWord[BIT_MISS:BIT_CRC] == '0);
  assert_write_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusWrite |=> !statusWrite);
  assert_monitor_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusWord[BIT_MON] == $past(monitorMode));
endmodule

// File: rtl/rxStatTally.sv
module rxStatTally
  import rxstat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        frameEnd,
  input  logic        crcOk,
  input  logic [2:0]  dribbleBits,
  input  logic        fifoOvf,
  input  logic        noBuffer,
  input  logic        multiMatch,
  input  logic        carrierSense,
  input  logic        jabber,
  input  logic        monitorMode,
  input  logic        saveErrored,
  input  logic [2:0]  rdTally,
  output logic [7:0]  statusWord,
  output logic        statusWrite,
  output logic [7:0]  crcTally,
  output logic [7:0]  alignTally,
  output logic [7:0]  missTally,
  output logic [2:0]  tallyMsb
);
  ctrlStrobes_t                         strb;
  logic [NUM_TALLY-1:0][CNT_W-1:0]      tallies;

  rxstat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .crcOk(crcOk), .dribbleBits(dribbleBits), .fifoOvf(fifoOvf),
    .noBuffer(noBuffer), .monitorMode(monitorMode), .saveErrored(saveErrored),
    .strb(strb)
  );

  rxstat_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .multiMatch(multiMatch),
    .monitorMode(monitorMode), .carrierSense(carrierSense), .jabber(jabber),
    .rdTally(rdTally), .statusWord(statusWord), .statusWrite(statusWrite),
    .tallies(tallies)
  );

  assign crcTally   = tallies[T_CRC];
  assign alignTally = tallies[T_ALIGN];
  assign missTally  = tallies[T_MISS];

  for (genvar i = 0; i < NUM_TALLY; i++) begin : g_msb
    assign tallyMsb[i] = tallies[i][CNT_W-1];
  end
endmodule

// File: tb/rxStatTally_tb.sv
module rxStatTally_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, frameEnd = 0, crcOk = 1, fifoOvf = 0, noBuffer = 0;
  logic multiMatch = 0, carrierSense = 0, jabber = 0, monitorMode = 0, saveErrored = 0;
  logic [2:0] dribbleBits = '0;
  logic [2:0] rdTally = '0;
  logic [7:0] statusWord, crcTally, alignTally, missTally;
  logic       statusWrite;
  logic [2:0] tallyMsb;

  int checks = 0;
  int fails  = 0;
  int expT[3];

  always #5 clk = ~clk;

  rxStatTally u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .crcOk(crcOk), .dribbleBits(dribbleBits), .fifoOvf(fifoOvf),
    .noBuffer(noBuffer), .multiMatch(multiMatch), .carrierSense(carrierSense),
    .jabber(jabber), .monitorMode(monitorMode), .saveErrored(saveErrored),
    .rdTally(rdTally), .statusWord(statusWord), .statusWrite(statusWrite),
    .crcTally(crcTally), .alignTally(alignTally), .missTally(missTally),
    .tallyMsb(tallyMsb)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] endWord(logic ok, logic [2:0] drib, logic nb, logic mon,
                                         logic multi, logic cs, logic jab);
    logic crcE, al, miss;
    crcE = !ok;
    al   = crcE && (drib >= 3'd6);
    miss = nb || mon;
    return {cs || jab, mon, multi, miss, 1'b0, al, crcE, !crcE && !miss};
  endfunction

  function automatic logic expWrite(logic ok, logic nb, logic mon, logic save);
    logic miss;
    miss = nb || mon;
    return !miss && (ok || save);
  endfunction

  function automatic int satInc(int v);
    return (v == 255) ? 255 : v + 1;
  endfunction

  task automatic checkTallies(input string req);
    check({req, " crcTally"},   32'(crcTally),   32'(expT[0]));
    check({req, " alignTally"}, 32'(alignTally), 32'(expT[1]));
    check({req, " missTally"},  32'(missTally),  32'(expT[2]));
    check("R12 tallyMsb", 32'(tallyMsb),
          {29'd0, expT[2] >= 128, expT[1] >= 128, expT[0] >= 128});
  endtask

  task automatic runFrame(input logic ok, input logic [2:0] drib, input logic ovf,
                          input logic nb, input logic multi, input logic mon,
                          input logic cs, input logic jab, input logic save,
                          input logic [2:0] rdMask);
    logic [7:0] exp;
    logic [7:0] held;
    logic inc[3];
    crcOk = ok; dribbleBits = drib; noBuffer = nb; multiMatch = multi;
    monitorMode = mon; carrierSense = cs; jabber = jab; saveErrored = save;
    frameStart = 1;
    tick();
    frameStart = 0;
    check("R2 start clears bits 5..0", 32'(statusWord[5:0]), 32'd0);
    tick();
    if (ovf) begin
      fifoOvf = 1;
      tick();
      fifoOvf = 0;
      exp = {cs || jab, mon, 6'b001000};
      check("R6 overflow status", 32'(statusWord), 32'(exp));
      check("R7 overflow write", 32'(statusWrite), 32'(save));
      held = statusWord;
      frameEnd = 1;
      tick();
      frameEnd = 0;
      check("R13 end after abort status", 32'(statusWord), 32'(held));
      check("R13 end after abort write", 32'(statusWrite), 32'd0);
      checkTallies("R6 no count on abort");
    end else begin
      inc[0] = !ok && !(drib >= 3'd6);
      inc[1] = !ok && (drib >= 3'd6);
      inc[2] = nb || mon;
      rdTally = rdMask;
      for (int i = 0; i < 3; i++)
        if (rdMask[i]) check("R11 value visible on read", 32'(i == 0 ? crcTally : i == 1 ? alignTally : missTally), 32'(expT[i]));
      frameEnd = 1;
      tick();
      frameEnd = 0;
      rdTally = '0;
      for (int i = 0; i < 3; i++) begin
        if (rdMask[i])   expT[i] = inc[i] ? 1 : 0;
        else if (inc[i]) expT[i] = satInc(expT[i]);
      end
      exp = endWord(ok, drib, nb, mon, multi, cs, jab);
      check("R3 R4 R5 frame end status", 32'(statusWord), 32'(exp));
      check("R7 end write", 32'(statusWrite), 32'(expWrite(ok, nb, mon, save)));
      checkTallies("R9 tallies");
    end
    tick();
    check("R7 write is one cycle", 32'(statusWrite), 32'd0);
  endtask

  task automatic readTally(input int idx);
    rdTally = 3'(1 << idx);
    check("R11 value before clear", 32'(idx == 0 ? crcTally : idx == 1 ? alignTally : missTally), 32'(expT[idx]));
    tick();
    rdTally = '0;
    expT[idx] = 0;
    checkTallies("R11 cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) expT[i] = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1 reset status", 32'(statusWord), 32'd0);
    check("R1 reset write", 32'(statusWrite), 32'd0);
    checkTallies("R1 reset");

    // R8: live bits track controls with no frame
    monitorMode = 1; carrierSense = 0; jabber = 1;
    tick();
    check("R8 live bits", 32'(statusWord[7:6]), 32'b11);
    monitorMode = 0; jabber = 0;
    tick();
    check("R8 live bits released", 32'(statusWord[7:6]), 32'b00);

    // directed frames
    runFrame(1, 3'd5, 0, 0, 0, 0, 0, 0, 0, 3'b000); // R4 good unicast
    runFrame(1, 3'd7, 0, 0, 1, 0, 1, 0, 0, 3'b000); // R3 good CRC with many dribble bits
    runFrame(0, 3'd5, 0, 0, 0, 0, 0, 0, 0, 3'b000); // R3 CRC only, not saved
    runFrame(0, 3'd6, 0, 0, 1, 0, 0, 0, 1, 3'b000); // R3 alignment + CRC, saved
    runFrame(1, 3'd0, 0, 1, 0, 0, 0, 0, 1, 3'b000); // R4 missed (no buffer)
    runFrame(1, 3'd0, 0, 0, 0, 1, 0, 0, 1, 3'b000); // R4 missed (monitor)
    runFrame(1, 3'd0, 1, 0, 1, 0, 0, 0, 1, 3'b000); // R6 overflow saved
    runFrame(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 3'b000); // R6 overflow dropped

    // R13: strobes outside a frame
    held = statusWord;
    crcOk = 0; dribbleBits = 3'd7; frameEnd = 1; fifoOvf = 1;
    tick();
    frameEnd = 0; fifoOvf = 0; crcOk = 1;
    check("R13 idle status", 32'(statusWord), 32'(held));
    check("R13 idle write", 32'(statusWrite), 32'd0);
    checkTallies("R13 idle");

    // R11 read with coincident increment
    runFrame(0, 3'd1, 0, 0, 0, 0, 0, 0, 0, 3'b001);
    check("R11 read plus increment", 32'(crcTally), 32'd1);
    readTally(1);
    readTally(2);

    // R10 saturation of the CRC tally
    for (int n = 0; n < 260; n++) runFrame(0, 3'd2, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    check("R10 saturated", 32'(crcTally), 32'd255);
    check("R12 msb flag", 32'(tallyMsb[0]), 32'd1);
    readTally(0);

    // random frames
    for (int n = 0; n < 400; n++) begin
      runFrame(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
               1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
               1'($urandom_range(0, 1)), $urandom_range(0, 5) == 0,
               1'($urandom_range(0, 1)),
               $urandom_range(0, 15) == 0 ? 3'($urandom_range(1, 7)) : 3'b000);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule